// File: doc/BRIEF.md
# Multi-Sender Buffer Handshake Controller

This block gathers 32-bit words from a set of senders into a four-entry queue and then hands them out to two receivers. Each side uses a four-phase request/acknowledge handshake. One sender at a time is acknowledged, and the choice rotates so that no sender waits for ever. The cycle in which an acknowledge rises is also the cycle in which a word is written: an enqueue strobe and a sender index go to a word multiplexer whose output feeds the queue. Senders are accepted as long as the queue has room. They never wait for a receiver to become free.

On the output side the controller offers the oldest queued word to receiver 0, then receiver 1, then receiver 0 again, and so on. A word leaves the queue in the cycle where the receiver that took it drops its acknowledge. The queue and the multiplexer are small behavioural submodules, so the whole path can be exercised from sender pins to receiver pins.

Top module: `msbuf_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every sender acknowledge, both receiver requests, the enqueue strobe and the dequeue strobe are low. The sender rotation starts at sender 0 and the receiver turn starts at receiver 0.
- R2: A sender acknowledge goes high only if that sender's request was high in the cycle before. So it never rises in the cycle in which its request rises.
- R3: A sender acknowledge stays high for as long as the request stays high. It goes low in the cycle after the request is seen low.
- R4: At most one sender acknowledge is high in any cycle.
- R5: Grants rotate. A new acknowledge goes to the first sender, in circular order after the most recently granted one, whose request was high in the previous cycle. Before the first grant the search starts at sender 0.
- R6: The enqueue strobe is high in exactly those cycles where some sender acknowledge rises. In that cycle the select output holds that sender's index, which is its bit position in the request vector. The word on that sender's bus in that cycle is the one stored.
- R7: Suppose in some cycle no sender acknowledge is high, the queue holds fewer than four words, and some request is high. Then an acknowledge, and with it an enqueue, rises in the next cycle, whatever the receivers are doing.
- R8: The queue holds at most four words. No acknowledge is granted while it holds four. Words reach the receivers in the order they were enqueued.
- R9: The two receiver requests are never high together. Successive receiver requests alternate between receivers, and the first one goes to receiver 0.
- R10: A receiver request stays high until its acknowledge is seen. It goes low in the next cycle. The same request rises again no earlier than two cycles after that acknowledge has fallen.
- R11: The dequeue strobe is high exactly in the cycles where a receiver acknowledge falls. While a receiver request is high, the receiver data bus shows the oldest queued word.
- R12: Every accepted word is eventually delivered, so the queue drains to empty once the senders stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_req | input | N_SND | Per-sender request |
| snd_data | input | N_SND*DW | Sender words; sender i occupies bits i*DW upward |
| snd_ack | output | N_SND | Per-sender acknowledge |
| enq_o | output | 1 | Enqueue strobe, high in the cycle a word is accepted |
| sel_o | output | clog2(N_SND) | Index of the sender being enqueued |
| deq_o | output | 1 | Dequeue strobe, high in the cycle a word leaves |
| rcv_req | output | 2 | Per-receiver request |
| rcv_ack | input | 2 | Per-receiver acknowledge |
| rcv_data | output | DW | Oldest queued word, shared by both receivers |

## Verification
An enqueue and a dequeue can land in the same cycle. This happens when a sender acknowledge rises in the same cycle that a receiver drops its acknowledge. The bench provokes it by running every sender back to back while the receivers answer at once, and it counts the cycles where both strobes are high. In those cycles it judges the outcome with its own occupancy model, which adds one word per enqueue and removes one per dequeue. The model must never go past four words, and every word the receivers pick up must match the scoreboard in order. A separate phase with the receivers stalled fills the queue to four words. It then confirms that the waiting senders get no acknowledge until a dequeue frees a slot.

// File: rtl/msb_pkg.sv
package msb_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_REQ   = 2'd1,
        RX_DRAIN = 2'd2
    } rx_state_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/msb_fifo.sv
module msb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);
    localparam int PW = msb_pkg::idx_w(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_s;

    fifo_s q, d;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign rd_data = q.mem[q.rp];

    always_comb begin
        d = q;
        if (wr_en) begin
            d.mem[q.wp] = wr_data;
            d.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (rd_en) begin
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({wr_en, rd_en})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a write while full is only allowed together with a read
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!full || rd_en));

    // R11: a dequeue never hits an empty queue
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/msb_mux.sv
module msb_mux #(
    parameter int N_SND = 4,
    parameter int DW    = 32,
    localparam int SEL_W = msb_pkg::idx_w(N_SND)
) (
    input  logic [N_SND*DW-1:0] data_in,
    input  logic [SEL_W-1:0]    sel,
    output logic [DW-1:0]       data_out
);
    always_comb begin
        data_out = '0;
        for (int i = 0; i < N_SND; i++) begin
            if (sel == SEL_W'(i)) data_out = data_in[i*DW +: DW];
        end
    end
endmodule

// File: rtl/msb_snd_arb.sv
module msb_snd_arb #(
    parameter int N_SND = 4,
    localparam int SEL_W = msb_pkg::idx_w(N_SND)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SND-1:0] snd_req,
    input  logic             fifo_full,
    output logic [N_SND-1:0] snd_ack,
    output logic             enq,
    output logic [SEL_W-1:0] sel
);
    typedef struct packed {
        logic [N_SND-1:0] ack;
        logic             enq;
        logic [SEL_W-1:0] sel;
        logic [SEL_W-1:0] rr;
    } arb_s;

    arb_s q, d;

    assign snd_ack = q.ack;
    assign enq     = q.enq;
    assign sel     = q.sel;

    always_comb begin
        logic found;
        int   pick;
        int   idx;
        d     = q;
        d.enq = 1'b0;
        d.ack = q.ack & snd_req;
        found = 1'b0;
        pick  = 0;
        idx   = 0;
        if ((q.ack == '0) && !fifo_full) begin
            for (int k = 0; k < N_SND; k++) begin
                idx = (int'(q.rr) + k) % N_SND;
                if (!found && snd_req[idx]) begin
                    found = 1'b1;
                    pick  = idx;
                end
            end
            if (found) begin
                d.ack[pick] = 1'b1;
                d.enq       = 1'b1;
                d.sel       = SEL_W'(pick);
                d.rr        = SEL_W'((pick + 1) % N_SND);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: acknowledges are mutually exclusive
    p_one_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snd_ack));

    for (genvar g = 0; g < N_SND; g++) begin : g_chk
        // R2: an acknowledge rises only after a request seen the cycle before
        p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(snd_ack[g]) |-> $past(snd_req[g]));
        // R3: a held request keeps its acknowledge
        p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (snd_ack[g] && snd_req[g]) |=> snd_ack[g]);
    end

endmodule

// File: rtl/msb_rcv_seq.sv
module msb_rcv_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic [1:0] rcv_ack,
    output logic [1:0] rcv_req,
    output logic       deq
);
    import msb_pkg::*;

    typedef struct packed {
        rx_state_e  st;
        logic       turn;
        logic [1:0] req;
        logic [1:0] ack_prev;
    } rx_s;

    rx_s q, d;

    assign rcv_req = q.req;
    assign deq     = (q.st == RX_DRAIN) && q.ack_prev[q.turn] && !rcv_ack[q.turn];

    always_comb begin
        d          = q;
        d.ack_prev = rcv_ack;
        case (q.st)
            RX_IDLE: begin
                if (!fifo_empty) begin
                    d.req[q.turn] = 1'b1;
                    d.st          = RX_REQ;
                end
            end
            RX_REQ: begin
                if (rcv_ack[q.turn]) begin
                    d.req = '0;
                    d.st  = RX_DRAIN;
                end
            end
            RX_DRAIN: begin
                if (deq) begin
                    d.st   = RX_IDLE;
                    d.turn = ~q.turn;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, turn: 1'b0, req: 2'b00, ack_prev: 2'b00};
        else        q <= d;
    end

    // R9: never request both receivers
    p_rcv_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rcv_req[0] && rcv_req[1]));

    for (genvar g = 0; g < 2; g++) begin : g_chk
        // R10: request held until acknowledged
        p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (rcv_req[g] && !rcv_ack[g]) |=> rcv_req[g]);
        // R10: no new request while the previous acknowledge is still up
        p_no_early_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rcv_req[g]) |-> !$past(rcv_ack[g]));
    end

endmodule

// File: rtl/msbuf_ctrl.sv
module msbuf_ctrl #(
    parameter int N_SND = 4,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int SEL_W = msb_pkg::idx_w(N_SND)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SND-1:0]    snd_req,
    input  logic [N_SND*DW-1:0] snd_data,
    output logic [N_SND-1:0]    snd_ack,
    output logic                enq_o,
    output logic [SEL_W-1:0]    sel_o,
    output logic                deq_o,
    output logic [1:0]          rcv_req,
    input  logic [1:0]          rcv_ack,
    output logic [DW-1:0]       rcv_data
);
    logic          full, empty;
    logic [DW-1:0] mux_word;

    msb_snd_arb #(.N_SND(N_SND)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .snd_req   (snd_req),
        .fifo_full (full),
        .snd_ack   (snd_ack),
        .enq       (enq_o),
        .sel       (sel_o)
    );

    msb_mux #(.N_SND(N_SND), .DW(DW)) u_mux (
        .data_in  (snd_data),
        .sel      (sel_o),
        .data_out (mux_word)
    );

    msb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (enq_o),
        .wr_data (mux_word),
        .rd_en   (deq_o),
        .rd_data (rcv_data),
        .full    (full),
        .empty   (empty)
    );

    msb_rcv_seq u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (empty),
        .rcv_ack    (rcv_ack),
        .rcv_req    (rcv_req),
        .deq        (deq_o)
    );

    // R6: enqueue exactly when one acknowledge has just risen
    p_enq_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enq_o == ((snd_ack & ~$past(snd_ack)) != '0));

    // R6: the select names the acknowledged sender
    p_sel_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enq_o |-> snd_ack[sel_o]);

    // R11: dequeue only in a cycle where a receiver acknowledge dropped
    p_deq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        deq_o |-> ((rcv_ack & ~$past(rcv_ack)) == '0) && ($past(rcv_ack) != '0));

endmodule

// File: tb/msbuf_ctrl_tb.sv
module msbuf_ctrl_tb;
    localparam int N  = 4;
    localparam int DW = 32;
    localparam int SW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_b [N];
    logic [DW-1:0]   dat_b [N];
    logic [N-1:0]    snd_req;
    logic [N*DW-1:0] snd_data;
    logic [N-1:0]    snd_ack;
    logic            enq_o, deq_o;
    logic [SW-1:0]   sel_o;
    logic [1:0]      rcv_req;
    logic [1:0]      rcv_ack = 2'b00;
    logic [DW-1:0]   rcv_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] sb [$];
    bit stall = 1'b0;
    int cnt = 0;
    int enq_total = 0;
    int both_cnt = 0;
    int delivered = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            snd_req[i] = req_b[i];
            snd_data[i*DW +: DW] = dat_b[i];
        end
    end

    msbuf_ctrl #(.N_SND(N), .DW(DW), .DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_data(snd_data),
        .snd_ack(snd_ack), .enq_o(enq_o), .sel_o(sel_o), .deq_o(deq_o),
        .rcv_req(rcv_req), .rcv_ack(rcv_ack), .rcv_data(rcv_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(input int i, input logic [DW-1:0] w);
        @(negedge clk);
        req_b[i] = 1'b1;
        dat_b[i] = w;
        do @(negedge clk); while (!snd_ack[i]);
        sb.push_back(w);
        req_b[i] = 1'b0;
        @(negedge clk);
        chk(snd_ack[i] == 1'b0, "R3 ack drop after request low", DW'(snd_ack[i]), 0);
        @(negedge clk);
    endtask

    task automatic burst(input int i, input int n, input int base);
        for (int k = 0; k < n; k++) send(i, {8'(i + 8'hA0), 24'(base + k)});
    endtask

    // receiver model: acknowledge at once unless stalled, drop after request drops
    initial begin
        forever begin
            @(negedge clk);
            for (int j = 0; j < 2; j++) begin
                if (rcv_ack[j]) begin
                    chk(rcv_req[j] == 1'b0, "R10 request low the cycle after ack", DW'(rcv_req[j]), 0);
                    rcv_ack[j] = 1'b0;
                end else if (rcv_req[j] && !stall && rst_n) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R8 word delivered with empty scoreboard", rcv_data, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = sb.pop_front();
                        chk(rcv_data == e, "R11 R8 receiver word order", rcv_data, e);
                    end
                    delivered++;
                    rcv_ack[j] = 1'b1;
                end
            end
        end
    end

    // monitor
    initial begin
        logic [N-1:0] p_ack, p_req;
        logic [1:0]   p_rack, p_rreq;
        int last_grant, exp_turn, cyc, p_cnt;
        int last_fall [2];
        bit expect_grant;
        p_ack = '0; p_req = '0; p_rack = '0; p_rreq = '0;
        last_grant = N - 1; exp_turn = 0; cyc = 0; p_cnt = 0; expect_grant = 0;
        last_fall[0] = -10; last_fall[1] = -10;
        forever begin
            @(negedge clk);
            #2;
            cyc++;
            if (!rst_n) begin
                p_ack = '0; p_req = '0; p_rack = '0; p_rreq = '0;
                cnt = 0;
                continue;
            end
            begin
                logic [N-1:0] rise;
                logic [1:0] rfall, rqr, rqf;
                int g, eg;
                rise = snd_ack & ~p_ack;
                chk($countones(snd_ack) <= 1, "R4 single acknowledge", DW'(snd_ack), 0);
                chk((rise & ~p_req) == '0, "R2 ack rose without prior request", DW'(rise), 0);
                chk(enq_o == (rise != '0), "R6 enqueue matches ack rise", DW'(enq_o), DW'(rise != '0));
                g = -1;
                for (int i = 0; i < N; i++) if (rise[i]) g = i;
                if (g >= 0) begin
                    chk(sel_o == SW'(g), "R6 select index", DW'(sel_o), DW'(g));
                    eg = -1;
                    for (int k = 1; k <= N; k++) begin
                        int c;
                        c = (last_grant + k) % N;
                        if (eg < 0 && p_req[c]) eg = c;
                    end
                    chk(g == eg, "R5 rotating grant", DW'(g), DW'(eg));
                    chk(p_cnt < 4, "R8 grant while queue full", DW'(p_cnt), 3);
                    last_grant = g;
                    enq_total++;
                end
                if (expect_grant) chk(rise != '0, "R7 prompt acceptance", DW'(rise), 1);
                expect_grant = (snd_ack == '0) && (cnt < 4) && (snd_req != '0);
                rfall = p_rack & ~rcv_ack;
                chk(deq_o == (rfall != '0), "R11 dequeue on ack fall", DW'(deq_o), DW'(rfall != '0));
                chk(!(rcv_req[0] && rcv_req[1]), "R9 receiver exclusion", DW'(rcv_req), 0);
                rqr = rcv_req & ~p_rreq;
                rqf = p_rreq & ~rcv_req;
                for (int j = 0; j < 2; j++) begin
                    if (rfall[j]) last_fall[j] = cyc;
                    if (rqr[j]) begin
                        chk(j == exp_turn, "R9 receiver alternation", DW'(j), DW'(exp_turn));
                        chk(cyc - last_fall[j] >= 2, "R10 re-raise spacing", DW'(cyc - last_fall[j]), 2);
                        exp_turn = 1 - j;
                    end
                    if (rqf[j]) chk(p_rack[j] == 1'b1, "R10 request dropped before ack", 0, 1);
                end
                if (enq_o && deq_o) both_cnt++;
                p_cnt = cnt;
                cnt = cnt + int'(enq_o) - int'(deq_o);
                chk(cnt >= 0 && cnt <= 4, "R8 occupancy bound", DW'(cnt), 4);
                p_ack = snd_ack; p_req = snd_req; p_rack = rcv_ack; p_rreq = rcv_req;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int e0;
        for (int i = 0; i < N; i++) begin req_b[i] = 1'b0; dat_b[i] = '0; end
        repeat (3) @(negedge clk);
        chk(snd_ack == '0 && rcv_req == '0 && !enq_o && !deq_o, "R1 outputs low in reset",
            DW'({snd_ack, rcv_req, enq_o, deq_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(snd_ack == '0 && rcv_req == '0 && !enq_o && !deq_o, "R1 outputs low after reset",
            DW'({snd_ack, rcv_req, enq_o, deq_o}), 0);

        // single word from sender 2
        send(2, 32'hDEAD_0002);
        repeat (10) @(negedge clk);

        // all senders at once: rotation after sender 2 is 3,0,1,2
        fork
            send(0, 32'h1111_0000);
            send(1, 32'h1111_0001);
            send(2, 32'h1111_0002);
            send(3, 32'h1111_0003);
        join
        repeat (20) @(negedge clk);

        // receivers stalled: queue fills to four, rest must wait
        stall = 1'b1;
        e0 = enq_total;
        fork
            burst(0, 2, 16'h100);
            burst(1, 2, 16'h200);
            burst(2, 1, 16'h300);
            burst(3, 1, 16'h400);
        join_none
        repeat (40) @(negedge clk);
        chk(enq_total - e0 == 4, "R8 four words accepted while stalled", DW'(enq_total - e0), 4);
        chk(cnt == 4, "R8 queue full", DW'(cnt), 4);
        chk(snd_ack == '0, "R8 no grant while full", DW'(snd_ack), 0);
        stall = 1'b0;
        wait fork;
        repeat (20) @(negedge clk);

        // streaming: enqueue and dequeue overlap
        fork
            burst(0, 6, 16'h500);
            burst(1, 6, 16'h600);
            burst(2, 6, 16'h700);
            burst(3, 6, 16'h800);
        join

        for (int k = 0; k < 300 && (sb.size() != 0 || cnt != 0); k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R12 all words delivered", DW'(sb.size()), 0);
        chk(cnt == 0, "R12 queue drained", DW'(cnt), 0);
        chk(delivered == enq_total, "R12 delivered equals accepted", DW'(delivered), DW'(enq_total));
        $display("[TB] info: %0d cycles with enqueue and dequeue together", both_cnt);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule